// File: doc/BRIEF.md
# Flag-Generating ALU with Branch Evaluator

This block executes one two-operand integer operation per accepted request, of the form `dst = dst op src`, at byte, word or long operand width. It stores the result and a 16-bit status word in registers that update on the clock edge where `valid_i` is high. The status word holds carry, parity, auxiliary carry, zero, sign and overflow. These flags are derived at the selected width, so bit 7, 15 or 31 acts as the sign position.

A purely combinational evaluator reads the stored flags together with a condition code and reports whether a conditional jump would be taken. This gives an execute stage both the data path and the branch decision. The evaluator covers the signed, unsigned and equality conditions, and also overflow and carry tests.

Top module: `flag_alu`

## Requirements
- R1: Op codes are ADD=0, SUB=1, INC=2, DEC=3, NEG=4, CMP=5, AND=6, OR=7, XOR=8, NOT=9, SHL=10, SAR=11. SUB gives dst−src, INC gives dst+1, DEC gives dst−1, NEG gives 0−dst and NOT gives ~dst. `res_o` takes the new result on the edge after `valid_i`=1 is sampled.
- R2: Size code 0 selects byte, 1 selects word, 2 or 3 selects long. Operand bits above the width are ignored, and `res_o` is zero-extended from that width.
- R3: CMP updates the flags exactly as SUB does and leaves `res_o` unchanged.
- R4: Status word layout: carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Bit 1 always reads 1 and every other bit reads 0. After reset, `res_o`=0 and `flags_o`=16'h0002.
- R5: For ADD/SUB/CMP/NEG, carry is the carry out of the width (borrow for subtraction forms, so NEG sets it when dst≠0). Overflow is the signed overflow at the width.
- R6: Zero is set when the width-masked result is 0. Sign is the top bit of the result at the width. Parity is set when the low 8 result bits hold an even number of ones.
- R7: For the arithmetic ops, auxiliary carry is the carry (or borrow) out of bit 3. Logic ops and shifts clear it.
- R8: INC and DEC leave carry unchanged and update all other flags.
- R9: AND, OR, XOR and NOT clear carry and overflow.
- R10: The shift count is src[4:0]. SHL moves in zeros, sets carry to the last bit shifted out and sets overflow to sign XOR carry. SAR copies the sign bit in, sets carry to the last bit shifted out and clears overflow.
- R11: A shift with count 0 writes the masked dst to `res_o` and leaves every flag unchanged.
- R12: While `valid_i`=0, `res_o` and `flags_o` hold their values.
- R13: `taken_o` is combinational from the stored flags and `cond_i`. Codes: EQ=0 (Z), NE=1, G=2 (!Z & S==O), GE=3 (S==O), L=4 (S!=O), LE=5 (Z | S!=O), A=6 (!C & !Z), AE=7 (!C), B=8 (C), BE=9 (C|Z), O=10, NO=11, C=12, NC=13. Codes 14 and 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the presented operation on this edge |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| src_i | input | 32 | Source operand / shift count |
| dst_i | input | 32 | Destination operand |
| cond_i | input | 4 | Branch condition code |
| res_o | output | 32 | Registered result |
| flags_o | output | 16 | Registered status word |
| taken_o | output | 1 | Branch condition holds on stored flags |

## Verification
A wrong flag bit appears on `flags_o` one edge after the operation. It then changes `taken_o` at once for every condition that reads that flag. An error in the sign position or carry alignment shows only at byte or word size, so the directed cases cross the 7/15/31 boundaries at every size. Faults in state retention are visible only across successive operations: a clobbered carry after INC or DEC, changed flags after a zero-count shift, or a changed result after CMP. The bench therefore chains these operations and compares each intermediate state.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 16;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int CF_BIT = 0;
  localparam int ONE_BIT = 1;
  localparam int PF_BIT = 2;
  localparam int AF_BIT = 4;
  localparam int ZF_BIT = 6;
  localparam int SF_BIT = 7;
  localparam int OF_BIT = 11;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_INC = 4'd2, OP_DEC = 4'd3,
    OP_NEG = 4'd4, OP_CMP = 4'd5, OP_AND = 4'd6, OP_OR  = 4'd7,
    OP_XOR = 4'd8, OP_NOT = 4'd9, OP_SHL = 4'd10, OP_SAR = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2} alu_sz_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0, CC_NE = 4'd1, CC_G  = 4'd2, CC_GE = 4'd3,
    CC_L  = 4'd4, CC_LE = 4'd5, CC_A  = 4'd6, CC_AE = 4'd7,
    CC_B  = 4'd8, CC_BE = 4'd9, CC_O  = 4'd10, CC_NO = 4'd11,
    CC_C  = 4'd12, CC_NC = 4'd13
  } alu_cc_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } flags_t;
endpackage

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_pkg::*;
(
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  flags_t            old_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            new_o,
  output logic              wr_res_o,
  output logic              wr_flags_o
);
  localparam logic [DATA_W-1:0] ALL1 = {DATA_W{1'b1}};

  logic [CNT_W-1:0]  sh, cnt;
  logic [DATA_W-1:0] mask, d, s, a, b, a_al, b_al, cin_al, d_al, sx;
  logic [DATA_W-1:0] ar_res, sar_res, shl_res, lg_res, r;
  logic [DATA_W:0]   sum, shl_w, sar_w;
  logic              cin, is_sub, ar_cf, ar_of, ar_af;
  logic              shl_cf, shl_of, sar_cf;
  logic              zf_c, sf_c, pf_c, is_logic, is_shift;

  always_comb begin
    case (size_i)
      SZ_B:    sh = CNT_W'(DATA_W - 8);
      SZ_W:    sh = CNT_W'(DATA_W - 16);
      default: sh = '0;
    endcase
    mask = ALL1 >> sh;
    d    = dst_i & mask;
    s    = src_i & mask;
    cnt  = src_i[CNT_W-1:0];

    // adder operand selection; subtraction forms use a + ~b + 1
    a = d; b = s; cin = 1'b0; is_sub = 1'b0;
    case (op_i)
      OP_SUB, OP_CMP: begin b = ~s & mask; cin = 1'b1; is_sub = 1'b1; end
      OP_INC:         b = DATA_W'(1);
      OP_DEC:         begin b = ~DATA_W'(1) & mask; cin = 1'b1; is_sub = 1'b1; end
      OP_NEG:         begin a = '0; b = ~d & mask; cin = 1'b1; is_sub = 1'b1; end
      default: ;
    endcase

    // left-align so carry/overflow fall at the top of a fixed adder
    a_al   = a << sh;
    b_al   = b << sh;
    cin_al = {{(DATA_W-1){1'b0}}, cin} << sh;
    sum    = {1'b0, a_al} + {1'b0, b_al} + {1'b0, cin_al};
    ar_res = sum[DATA_W-1:0] >> sh;
    ar_cf  = sum[DATA_W] ^ is_sub;
    ar_of  = (a_al[DATA_W-1] == b_al[DATA_W-1]) && (sum[DATA_W-1] != a_al[DATA_W-1]);
    ar_af  = a[4] ^ b[4] ^ ar_res[4] ^ is_sub;

    d_al    = d << sh;
    shl_w   = {1'b0, d_al} << cnt;
    shl_res = shl_w[DATA_W-1:0] >> sh;
    shl_cf  = shl_w[DATA_W];
    shl_of  = shl_w[DATA_W-1] ^ shl_cf;

    sx      = $signed(d_al) >>> sh;
    sar_w   = $signed({sx, 1'b0}) >>> cnt;
    sar_res = sar_w[DATA_W:1] & mask;
    sar_cf  = sar_w[0];

    case (op_i)
      OP_AND:  lg_res = d & s;
      OP_OR:   lg_res = d | s;
      OP_XOR:  lg_res = d ^ s;
      default: lg_res = ~d & mask;
    endcase

    is_logic = (op_i == OP_AND) || (op_i == OP_OR) || (op_i == OP_XOR) || (op_i == OP_NOT);
    is_shift = (op_i == OP_SHL) || (op_i == OP_SAR);

    if (is_logic)            r = lg_res;
    else if (op_i == OP_SHL) r = shl_res;
    else if (op_i == OP_SAR) r = sar_res;
    else                     r = ar_res;

    zf_c = (r == '0);
    case (size_i)
      SZ_B:    sf_c = r[7];
      SZ_W:    sf_c = r[15];
      default: sf_c = r[DATA_W-1];
    endcase
    pf_c = ~^r[7:0];

    new_o      = old_i;
    new_o.zf_f = zf_c;
    new_o.sf_f = sf_c;
    new_o.pf_f = pf_c;
    if (is_logic) begin
      new_o.cf_f = 1'b0;
      new_o.of_f = 1'b0;
      new_o.af_f = 1'b0;
    end else if (op_i == OP_SHL) begin
      new_o.cf_f = shl_cf;
      new_o.of_f = shl_of;
      new_o.af_f = 1'b0;
    end else if (op_i == OP_SAR) begin
      new_o.cf_f = sar_cf;
      new_o.of_f = 1'b0;
      new_o.af_f = 1'b0;
    end else begin
      if (op_i != OP_INC && op_i != OP_DEC) new_o.cf_f = ar_cf;
      new_o.of_f = ar_of;
      new_o.af_f = ar_af;
    end

    res_o      = r;
    wr_res_o   = (op_i != OP_CMP);
    wr_flags_o = !(is_shift && cnt == '0);
  end
endmodule

// File: rtl/cond_eval.sv
`timescale 1ns/1ps
module cond_eval
  import alu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  logic       cf_i,
  input  logic       zf_i,
  input  logic       sf_i,
  input  logic       of_i,
  output logic       taken_o
);
  logic lt, le, be;

  always_comb begin
    lt = sf_i ^ of_i;
    le = lt | zf_i;
    be = cf_i | zf_i;
    case (cond_i)
      CC_EQ:   taken_o = zf_i;
      CC_NE:   taken_o = ~zf_i;
      CC_G:    taken_o = ~le;
      CC_GE:   taken_o = ~lt;
      CC_L:    taken_o = lt;
      CC_LE:   taken_o = le;
      CC_A:    taken_o = ~be;
      CC_AE:   taken_o = ~cf_i;
      CC_B:    taken_o = cf_i;
      CC_BE:   taken_o = be;
      CC_O:    taken_o = of_i;
      CC_NO:   taken_o = ~of_i;
      CC_C:    taken_o = cf_i;
      CC_NC:   taken_o = ~cf_i;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
  import alu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [3:0]        cond_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              taken_o
);
  flags_t            flags_q, flags_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              wr_res, wr_flags;

  alu_core u_core (
    .op_i      (op_i),
    .size_i    (size_i),
    .src_i     (src_i),
    .dst_i     (dst_i),
    .old_i     (flags_q),
    .res_o     (res_d),
    .new_o     (flags_d),
    .wr_res_o  (wr_res),
    .wr_flags_o(wr_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (valid_i) begin
      if (wr_res)   res_q   <= res_d;
      if (wr_flags) flags_q <= flags_d;
    end
  end

  always_comb begin
    flags_o          = '0;
    flags_o[ONE_BIT] = 1'b1;
    flags_o[CF_BIT]  = flags_q.cf_f;
    flags_o[PF_BIT]  = flags_q.pf_f;
    flags_o[AF_BIT]  = flags_q.af_f;
    flags_o[ZF_BIT]  = flags_q.zf_f;
    flags_o[SF_BIT]  = flags_q.sf_f;
    flags_o[OF_BIT]  = flags_q.of_f;
  end
  assign res_o = res_q;

  cond_eval u_cond (
    .cond_i (cond_i),
    .cf_i   (flags_q.cf_f),
    .zf_i   (flags_q.zf_f),
    .sf_i   (flags_q.sf_f),
    .of_i   (flags_q.of_f),
    .taken_o(taken_o)
  );

  // R4
  fixed_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[ONE_BIT] && flags_o[3] == 1'b0 && flags_o[5] == 1'b0 &&
    flags_o[10:8] == 3'b000 && flags_o[FLAG_W-1:12] == '0);
  // R3
  cmp_keeps_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> $stable(res_o));
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(flags_o));
  // R8
  incdec_cf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_INC || op_i == OP_DEC) |=> flags_o[CF_BIT] == $past(flags_o[CF_BIT]));
  // R9
  logic_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_NOT)
    |=> !flags_o[CF_BIT] && !flags_o[OF_BIT] && !flags_o[AF_BIT]);
  // R11
  zero_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_SHL || op_i == OP_SAR) && src_i[CNT_W-1:0] == '0 |=> $stable(flags_o));
  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_AND || op_i == OP_XOR)
    |=> flags_o[ZF_BIT] == (res_o == '0));
  // R13
  ne_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == CC_NE |-> taken_o != flags_o[ZF_BIT]);
endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] src = '0, dst = '0;
  logic [3:0]  cond = '0;
  logic [31:0] res;
  logic [15:0] flags;
  logic        taken;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu u_flag_alu (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .src_i(src), .dst_i(dst), .cond_i(cond), .res_o(res), .flags_o(flags), .taken_o(taken)
  );

  task automatic exec(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    op = o; size = sz; dst = d; src = s; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] er, input logic [15:0] ef);
    n_tests++;
    if (res !== er || flags !== ef) begin
      n_fail++;
      $display("FAIL %s res=%h exp=%h flags=%h exp=%h", tag, res, er, flags, ef);
    end
  endtask

  task automatic chk_cc(input string tag, input logic [3:0] c, input logic exp);
    cond = c;
    #1;
    n_tests++;
    if (taken !== exp) begin
      n_fail++;
      $display("FAIL %s cond=%0d taken=%b exp=%b", tag, c, taken, exp);
    end
  endtask

  task automatic t_reset;
    chk("R4 reset", 32'h0, 16'h0002);
  endtask

  task automatic t_add;
    exec(4'd0, 2'd0, 32'h7F, 32'h01);
    chk("R5 R7 add byte overflow", 32'h80, 16'h0892);
    exec(4'd0, 2'd0, 32'hFF, 32'h01);
    chk("R5 R6 add byte carry zero", 32'h00, 16'h0057);
  endtask

  task automatic t_sub_cmp;
    exec(4'd1, 2'd2, 32'h5, 32'h7);
    chk("R1 R5 sub long borrow", 32'hFFFF_FFFE, 16'h0093);
    exec(4'd5, 2'd1, 32'h8000, 32'h0001);
    chk("R3 cmp word keeps res", 32'hFFFF_FFFE, 16'h0816);
  endtask

  task automatic t_incdec;
    exec(4'd0, 2'd0, 32'hFF, 32'h01);
    exec(4'd2, 2'd0, 32'h0F, 32'h0);
    chk("R8 inc keeps carry", 32'h10, 16'h0013);
    exec(4'd3, 2'd1, 32'h0, 32'h0);
    chk("R8 dec word wrap", 32'hFFFF, 16'h0097);
  endtask

  task automatic t_neg;
    exec(4'd4, 2'd2, 32'h0, 32'h0);
    chk("R5 neg zero", 32'h0, 16'h0046);
    exec(4'd4, 2'd0, 32'h80, 32'h0);
    chk("R5 neg byte min", 32'h80, 16'h0883);
  endtask

  task automatic t_logic;
    exec(4'd6, 2'd2, 32'hF0F0_F0F0, 32'h0FF0_0FF0);
    chk("R9 and clears cf of", 32'h00F0_00F0, 16'h0006);
    exec(4'd8, 2'd0, 32'h5A, 32'h5A);
    chk("R9 xor zero", 32'h0, 16'h0046);
    exec(4'd7, 2'd1, 32'h8000, 32'h0001);
    chk("R6 or word sign", 32'h8001, 16'h0082);
    exec(4'd9, 2'd0, 32'h0F, 32'h0);
    chk("R1 not byte", 32'hF0, 16'h0086);
  endtask

  task automatic t_shift;
    exec(4'd10, 2'd0, 32'h81, 32'd1);
    chk("R10 shl byte", 32'h02, 16'h0803);
    exec(4'd11, 2'd0, 32'h81, 32'd1);
    chk("R10 sar byte", 32'hC0, 16'h0087);
    exec(4'd11, 2'd2, 32'h8000_0000, 32'd31);
    chk("R10 sar long 31", 32'hFFFF_FFFF, 16'h0086);
    exec(4'd10, 2'd1, 32'h1234, 32'd0);
    chk("R11 zero count", 32'h1234, 16'h0086);
  endtask

  task automatic t_size;
    exec(4'd0, 2'd1, 32'h0001_FFFF, 32'h0001_0001);
    chk("R2 word ignores upper", 32'h0, 16'h0057);
  endtask

  task automatic t_hold;
    @(negedge clk);
    op = 4'd0; size = 2'd2; dst = 32'h1; src = 32'h1; valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R12 idle hold", 32'h0, 16'h0057);
  endtask

  task automatic t_branch;
    exec(4'd1, 2'd2, 32'h5, 32'h7);
    chk_cc("R13 eq", 4'd0, 1'b0);  chk_cc("R13 ne", 4'd1, 1'b1);
    chk_cc("R13 g", 4'd2, 1'b0);   chk_cc("R13 ge", 4'd3, 1'b0);
    chk_cc("R13 l", 4'd4, 1'b1);   chk_cc("R13 le", 4'd5, 1'b1);
    chk_cc("R13 a", 4'd6, 1'b0);   chk_cc("R13 ae", 4'd7, 1'b0);
    chk_cc("R13 b", 4'd8, 1'b1);   chk_cc("R13 be", 4'd9, 1'b1);
    chk_cc("R13 o", 4'd10, 1'b0);  chk_cc("R13 no", 4'd11, 1'b1);
    chk_cc("R13 c", 4'd12, 1'b1);  chk_cc("R13 nc", 4'd13, 1'b0);
    chk_cc("R13 rsv", 4'd15, 1'b0);
    exec(4'd0, 2'd0, 32'h7F, 32'h01);
    chk_cc("R13 g ovf", 4'd2, 1'b1);  chk_cc("R13 l ovf", 4'd4, 1'b0);
    chk_cc("R13 a ovf", 4'd6, 1'b1);  chk_cc("R13 o ovf", 4'd10, 1'b1);
    exec(4'd0, 2'd0, 32'hFF, 32'h01);
    chk_cc("R13 eq z", 4'd0, 1'b1);   chk_cc("R13 ge z", 4'd3, 1'b1);
    chk_cc("R13 g z", 4'd2, 1'b0);    chk_cc("R13 le z", 4'd5, 1'b1);
  endtask

  initial begin
    #1;
    t_reset();
    #10 rst_n = 1'b1;
    t_add();
    t_sub_cmp();
    t_incdec();
    t_neg();
    t_logic();
    t_shift();
    t_size();
    t_hold();
    t_branch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule